// File: doc/BRIEF.md
# Flag-Setting Barrel Shifter Unit

This unit is the shift execution slice of a 32-bit core. Each cycle it can accept one shift instruction together with the two operand values the core has already read: the destination/source operand and the second register operand. It works out which shift is meant and how far to shift. It then registers the shifted value along with the carry, overflow, sign and zero flags. Register file access belongs to the surrounding core.

An instruction arrives as a 32-bit word. The first halfword sits in bits [15:0], and its opcode field in bits [10:5] picks the form. In the short form, the shift amount is the 5-bit immediate in bits [4:0], zero-extended. In the extended register form, the opcode field is all ones and the second halfword in bits [31:16] selects the operation. In that form the amount comes from the low five bits of the second operand. An encoding that matches neither form is reported as illegal.

The output side has two named states. `ST_IDLE` means no new result this cycle. `ST_RESULT` means the registers hold the result of the instruction accepted on the previous edge. Transition `T_ACCEPT` moves from either state to `ST_RESULT` when `in_valid` is high. Transition `T_DRAIN` moves from either state to `ST_IDLE` when `in_valid` is low. The result and flag registers keep their last values in `ST_IDLE`.

Top module: `shf_unit`

## Requirements
- R1: After reset, `out_valid`, `result`, `cy`, `ov`, `s`, `z` and `illegal` are all 0. An instruction accepted with `in_valid` high shows on the outputs, with `out_valid` high, after exactly one rising edge. While `in_valid` stays low, `out_valid` is 0 and the other outputs keep their values.
- R2: Short form: opcode `insn[10:5]` = 6'b010110 selects shift left logical, 6'b010100 selects shift right logical, and 6'b010101 selects shift right arithmetic. The amount is `insn[4:0]` zero-extended, and `reg1_val` is ignored.
- R3: Register form: `insn[10:5]` = 6'b111111. The second halfword `insn[31:16]` picks the operation: 16'h00C0 is shift left logical, 16'h0080 is shift right logical, 16'h00A0 is shift right arithmetic. Only `reg1_val[4:0]` sets the amount.
- R4: Shift left logical moves `reg2_val` toward bit 31 and fills the vacated low bits with 0.
- R5: Shift right logical moves `reg2_val` toward bit 0 and fills the vacated high bits with 0.
- R6: Shift right arithmetic fills the vacated high bits with bit 31 of the original `reg2_val`.
- R7: `cy` is the last bit shifted out. For a left shift by n this is original bit 32-n; for a right shift by n it is bit n-1. With an amount of 0, `cy` is 0 and `result` equals `reg2_val`.
- R8: `ov` is 0 after every shift.
- R9: `s` equals `result[31]`, and `z` is 1 exactly when `result` is zero, for every legal shift.
- R10: Any other opcode, and any register-form second halfword other than the three listed, sets `illegal` to 1, with `result` 0 and `cy`, `ov`, `s`, `z` all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| insn | input | 32 | First halfword in [15:0], second halfword in [31:16] |
| reg2_val | input | 32 | Value to be shifted |
| reg1_val | input | 32 | Register shift amount source, low 5 bits used |
| out_valid | output | 1 | Outputs hold a fresh result (state `ST_RESULT`) |
| result | output | 32 | Shifted value |
| cy | output | 1 | Carry: last bit shifted out |
| ov | output | 1 | Overflow, always cleared by a shift |
| s | output | 1 | Sign of result |
| z | output | 1 | Result is zero |
| illegal | output | 1 | Instruction is not a recognised shift |

## Verification
Every result and flag is due one rising edge after the cycle in which `in_valid` is high, because decode, shift and flag logic all feed a single output register. The bench changes inputs on the falling edge, lets one rising edge pass, and reads the outputs on the next falling edge. That is the only point at which a fresh result is compared. A separate idle cycle, in which `reg2_val` changes while `in_valid` is low, checks that the held values stay the same and that `out_valid` has dropped.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        OP_SLL = 2'd0,
        OP_SRL = 2'd1,
        OP_SRA = 2'd2,
        OP_BAD = 2'd3
    } shf_op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } shf_state_e;

    typedef struct packed {
        logic cy;
        logic ov;
        logic s;
        logic z;
    } shf_flags_t;

    localparam int          OPC_LSB     = 5;
    localparam int          OPC_W       = 6;
    localparam int          SUB_LSB     = 16;
    localparam int          SUB_W       = 16;

    localparam logic [5:0]  OPC_SLL_IMM = 6'b010110;
    localparam logic [5:0]  OPC_SRL_IMM = 6'b010100;
    localparam logic [5:0]  OPC_SRA_IMM = 6'b010101;
    localparam logic [5:0]  OPC_EXT     = 6'b111111;

    localparam logic [15:0] SUB_SLL     = 16'h00C0;
    localparam logic [15:0] SUB_SRL     = 16'h0080;
    localparam logic [15:0] SUB_SRA     = 16'h00A0;

endpackage

// File: rtl/shf_decode.sv
module shf_decode
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 5
) (
    input  logic [31:0]       insn,
    input  logic [DATA_W-1:0] reg1_val,
    output shf_op_e           op,
    output logic [AMT_W-1:0]  amt
);

    logic [OPC_W-1:0] opc;
    logic [SUB_W-1:0] sub;

    assign opc = insn[OPC_LSB +: OPC_W];
    assign sub = insn[SUB_LSB +: SUB_W];

    always_comb begin
        op  = OP_BAD;
        amt = '0;
        unique case (opc)
            OPC_SLL_IMM: begin
                op  = OP_SLL;
                amt = insn[AMT_W-1:0];
            end
            OPC_SRL_IMM: begin
                op  = OP_SRL;
                amt = insn[AMT_W-1:0];
            end
            OPC_SRA_IMM: begin
                op  = OP_SRA;
                amt = insn[AMT_W-1:0];
            end
            OPC_EXT: begin
                amt = reg1_val[AMT_W-1:0];
                unique case (sub)
                    SUB_SLL: op = OP_SLL;
                    SUB_SRL: op = OP_SRL;
                    SUB_SRA: op = OP_SRA;
                    default: op = OP_BAD;
                endcase
            end
            default: begin
                op  = OP_BAD;
                amt = '0;
            end
        endcase
    end

endmodule

// File: rtl/shf_barrel.sv
module shf_barrel
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 5
) (
    input  logic [DATA_W-1:0] data,
    input  logic [AMT_W-1:0]  amt,
    input  shf_op_e           op,
    output logic [DATA_W-1:0] res,
    output logic              cy_out
);

    // Left chain keeps the carry above the data word; right chain keeps it below.
    logic [DATA_W:0] lv [AMT_W+1];
    logic [DATA_W:0] rv [AMT_W+1];
    logic            fill;

    assign fill  = (op == OP_SRA) ? data[DATA_W-1] : 1'b0;
    assign lv[0] = {1'b0, data};
    assign rv[0] = {data, 1'b0};

    for (genvar g = 0; g < AMT_W; g++) begin : g_stage
        localparam int K = 1 << g;
        assign lv[g+1] = amt[g] ? {lv[g][DATA_W-K:0], {K{1'b0}}} : lv[g];
        assign rv[g+1] = amt[g] ? {{K{fill}}, rv[g][DATA_W:K]}  : rv[g];
    end

    always_comb begin
        unique case (op)
            OP_SLL: begin
                res    = lv[AMT_W][DATA_W-1:0];
                cy_out = lv[AMT_W][DATA_W];
            end
            OP_SRL, OP_SRA: begin
                res    = rv[AMT_W][DATA_W:1];
                cy_out = rv[AMT_W][0];
            end
            default: begin
                res    = '0;
                cy_out = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/shf_flag_gen.sv
module shf_flag_gen
    import shf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] res,
    input  logic              cy_in,
    input  logic              legal,
    output shf_flags_t        flags
);

    always_comb begin
        if (legal) begin
            flags.cy = cy_in;
            flags.ov = 1'b0;
            flags.s  = res[DATA_W-1];
            flags.z  = (res == '0);
        end else begin
            flags = '0;
        end
    end

endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       insn,
    input  logic [DATA_W-1:0] reg2_val,
    input  logic [DATA_W-1:0] reg1_val,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              cy,
    output logic              ov,
    output logic              s,
    output logic              z,
    output logic              illegal
);

    localparam int AMT_W = $clog2(DATA_W);

    shf_op_e           dec_op;
    logic [AMT_W-1:0]  dec_amt;
    logic [DATA_W-1:0] sh_res;
    logic              sh_cy;
    logic              legal;
    shf_flags_t        fl;
    shf_state_e        state_q;
    shf_state_e        state_d;

    shf_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_dec (
        .insn     (insn),
        .reg1_val (reg1_val),
        .op       (dec_op),
        .amt      (dec_amt)
    );

    shf_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_bar (
        .data   (reg2_val),
        .amt    (dec_amt),
        .op     (dec_op),
        .res    (sh_res),
        .cy_out (sh_cy)
    );

    assign legal = (dec_op != OP_BAD);

    shf_flag_gen #(.DATA_W(DATA_W)) u_flg (
        .res   (sh_res),
        .cy_in (sh_cy),
        .legal (legal),
        .flags (fl)
    );

    // Next state: T_ACCEPT on in_valid, T_DRAIN otherwise.
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result  <= '0;
            cy      <= 1'b0;
            ov      <= 1'b0;
            s       <= 1'b0;
            z       <= 1'b0;
            illegal <= 1'b0;
        end else if (state_d == ST_RESULT) begin
            result  <= legal ? sh_res : '0;
            cy      <= fl.cy;
            ov      <= fl.ov;
            s       <= fl.s;
            z       <= fl.z;
            illegal <= !legal;
        end
    end

    assign out_valid = (state_q == ST_RESULT);

endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [31:0]       insn,
    input logic [DATA_W-1:0] reg2_val,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              cy,
    input logic              ov,
    input logic              s,
    input logic              z,
    input logic              illegal
);

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(cy) && $stable(z)));

    assert_zero_amt_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && insn[10:5] == 6'b010110 && insn[4:0] == 5'd0)
        |=> (result == $past(reg2_val) && !cy));

    assert_sra_keeps_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && insn[10:5] == 6'b010101)
        |=> (result[DATA_W-1] == $past(reg2_val[DATA_W-1])));

    assert_ov_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !ov);

    assert_sign_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !illegal) |-> (s == result[DATA_W-1] && z == (result == '0)));

    assert_illegal_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && illegal) |-> (result == '0 && !cy && !s && !z));

    assert_bad_opcode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && insn[10:5] == 6'b000000) |=> illegal);

endmodule

bind shf_unit shf_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .insn      (insn),
    .reg2_val  (reg2_val),
    .out_valid (out_valid),
    .result    (result),
    .cy        (cy),
    .ov        (ov),
    .s         (s),
    .z         (z),
    .illegal   (illegal)
);

// File: tb/tb_shf_unit.sv
module tb_shf_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] reg2_val = '0;
    logic [31:0] reg1_val = '0;
    logic        out_valid, cy, ov, s, z, illegal;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    shf_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
        .reg2_val(reg2_val), .reg1_val(reg1_val), .out_valid(out_valid),
        .result(result), .cy(cy), .ov(ov), .s(s), .z(z), .illegal(illegal)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pattern(input int i);
        case (i)
            0: return 32'h00000000;
            1: return 32'hFFFFFFFF;
            2: return 32'h80000001;
            3: return 32'h7FFFFFFE;
            4: return 32'h12345678;
            5: return 32'hA5A5A5A5;
            6: return 32'h00000001;
            default: return 32'h80000000;
        endcase
    endfunction

    // Drive on falling edge, one rising edge, sample at next falling edge.
    task automatic issue(input logic [31:0] ins, input logic [31:0] r2, input logic [31:0] r1);
        @(negedge clk);
        in_valid = 1'b1;
        insn     = ins;
        reg2_val = r2;
        reg1_val = r1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] ins, d, exp_r;
        logic        exp_c;
        logic [5:0]  opc;
        logic [15:0] sub;
        string       tag;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset out_valid", {31'b0, out_valid}, 32'd0);
        check("R1 reset result", result, 32'd0);
        check("R1 reset flags", {27'b0, cy, ov, s, z, illegal}, 32'd0);
        rst_n = 1'b1;

        for (int form = 0; form < 2; form++) begin
            for (int op = 0; op < 3; op++) begin
                for (int p = 0; p < 8; p++) begin
                    for (int n = 0; n < 32; n++) begin
                        d = pattern(p);
                        if (form == 0) begin
                            opc = (op == 0) ? 6'b010110 : (op == 1) ? 6'b010100 : 6'b010101;
                            ins = {16'h0000, 5'd7, opc, n[4:0]};
                            // R2: reg1_val ignored, given a different amount
                            issue(ins, d, {27'h7FFFFFF, ~n[4:0]});
                            tag = "R2";
                        end else begin
                            sub = (op == 0) ? 16'h00C0 : (op == 1) ? 16'h0080 : 16'h00A0;
                            ins = {sub, 5'd9, 6'b111111, 5'd3};
                            // R3: upper bits of reg1_val must not matter
                            issue(ins, d, {27'h5A5A5A5 ^ 27'(p * 977), n[4:0]});
                            tag = "R3";
                        end
                        if (op == 0) begin
                            exp_r = d << n;
                            exp_c = (n == 0) ? 1'b0 : d[32-n];
                            tag = {tag, " R4 sll"};
                        end else if (op == 1) begin
                            exp_r = d >> n;
                            exp_c = (n == 0) ? 1'b0 : d[n-1];
                            tag = {tag, " R5 srl"};
                        end else begin
                            exp_r = $unsigned($signed(d) >>> n);
                            exp_c = (n == 0) ? 1'b0 : d[n-1];
                            tag = {tag, " R6 sra"};
                        end
                        check({tag, " result"}, result, exp_r);
                        check("R7 carry", {31'b0, cy}, {31'b0, exp_c});
                        check("R8 ov", {31'b0, ov}, 32'd0);
                        check("R9 s z", {30'b0, s, z}, {30'b0, exp_r[31], exp_r == 32'd0});
                        check("R1 valid legal", {30'b0, out_valid, illegal}, 32'd2);
                    end
                end
            end
        end

        // R1 hold while idle
        issue({16'h0, 5'd1, 6'b010110, 5'd4}, 32'h0000_0F0F, 32'd0);
        check("R1 fresh result", result, 32'h0000_F0F0);
        @(negedge clk);
        reg2_val = 32'hDEAD_BEEF;
        @(negedge clk);
        check("R1 idle out_valid", {31'b0, out_valid}, 32'd0);
        check("R1 idle hold result", result, 32'h0000_F0F0);

        // R10 illegal encodings
        for (int k = 0; k < 6; k++) begin
            case (k)
                0: ins = {16'h0000, 5'd2, 6'b000000, 5'd3};
                1: ins = {16'h00C1, 5'd2, 6'b111111, 5'd3};
                2: ins = {16'h0000, 5'd2, 6'b111111, 5'd3};
                3: ins = {16'h0000, 5'd2, 6'b010111, 5'd3};
                4: ins = {16'h0040, 5'd2, 6'b111111, 5'd3};
                default: ins = {16'h0000, 5'd2, 6'b110110, 5'd3};
            endcase
            issue(ins, 32'h8000_00F1, 32'd5);
            check("R10 illegal flag", {31'b0, illegal}, 32'd1);
            check("R10 illegal result", result, 32'd0);
            check("R10 illegal flags", {28'b0, cy, ov, s, z}, 32'd0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule